// File: doc/BRIEF.md
# Memory Carveout Access Checker

This block sits beside a memory controller's request path and guards physical memory against clients that may not touch it. It holds a small set of programmable protected regions. Each region has a start address split over two words, a length counted in 128 KB units, a bitmap of the clients allowed to read or write it, and a configuration word. The configuration word sets which access levels may enter, which level checks are turned off, whether secure-world traffic skips the check, and whether the region's registers are frozen.

Each request presents a client number, a direction, a physical address, a secure flag and an access level. One cycle later the block returns a verdict. A request that lands in no active region is allowed. A request that lands in several regions must satisfy all of them. When a request is refused, a one-cycle violation pulse carries the number of the lowest-numbered region that refused it. The registers are reached through a simple word-wide write port with a combinational read-back.

Top module: `carveout_guard`

## Requirements
- R1: After reset every register word reads 0, `respValid` and `violPulse` are low, and every request is allowed because every region is empty.
- R2: A region covers an address when base <= addr < base + size*128 KB. The base in 128 KB units is {high word bits 7:0, low word bits 31:17}. Address bits 16:0 are not compared. A size of 0 covers nothing.
- R3: The five access words of a region form a 160-bit whitelist. Word k holds bits 32k to 32k+31. A request uses bit index 2*client + write, where write is 1 for a write. An index of 160 or more counts as a cleared bit. Inside a region, a request with a cleared bit is refused unless the secure bypass in R5 applies.
- R4: Level masks sit in configuration bits 6:3 for reads and 10:7 for writes, with bit n of a mask for level n. Check-disable masks sit in bits 17:14 for reads and 21:18 for writes. Inside a region, a request whose level bit is clear in both the mask and the disable mask for its direction is refused unless R5 applies.
- R5: Configuration bit 23 lets secure writes pass the region, and bit 24 does the same for secure reads. Either bypass applies only to requests that carry the secure flag and have that direction.
- R6: A request outside every region is allowed. A request inside several regions is allowed only if every region that covers it allows it.
- R7: `respValid`, `respAllow`, `violPulse` and `violRegion` appear exactly one clock after `reqValid`. A refusal gives a single-cycle `violPulse`, `respAllow` low, and `violRegion` set to the lowest-numbered refusing region.
- R8: The register address is {region[2:0], field[3:0]}. Field 0 is the base low word, 1 the base high word, 2 the size, 3 the configuration, and 4 to 8 access words 0 to 4. `regRdata` shows the addressed word with no delay. Other fields, and regions at or above the region count, read 0 and ignore writes.
- R9: While configuration bit 1 (lock) is set, writes to that region's registers are ignored, the configuration word included. The one exception is a write with `regSecure` high while configuration bit 0 (protect mode) is 1.
- R10: A lock affects only its own region. Writes to other regions still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 7 | Register word address {region, field} |
| regWdata | input | 32 | Register write data |
| regSecure | input | 1 | Write comes from the secure world |
| regRdata | output | 32 | Read-back of the addressed word |
| reqValid | input | 1 | Request present this cycle |
| reqClient | input | 7 | Requesting client number |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqSecure | input | 1 | Request is secure-world traffic |
| reqLevel | input | 2 | Access level 0 to 3 |
| reqAddr | input | 40 | Physical address |
| respValid | output | 1 | Verdict present |
| respAllow | output | 1 | Request allowed |
| violPulse | output | 1 | One-cycle refusal pulse |
| violRegion | output | 3 | Lowest refusing region |

## Verification
A wrong stored base, size or whitelist bit shows up at the next request near that region's edge. The verdict flips one clock after the request, and `regRdata` exposes the bad word with no delay. A lock that leaks or sticks shows in the very next read-back of the region it guards. A wrong priority among overlapping regions shows in `violRegion` on the first refusal that more than one region causes. Each case is therefore probed with a boundary request or a read-back straight after the stimulus.

// File: rtl/cg_pkg.sv
package cg_pkg;
  localparam int CG_MAX_REGIONS = 8;
  localparam int CG_WORD_W      = 32;
  localparam int CG_FIELD_W     = 4;

  typedef enum logic [3:0] {
    FLD_BASE_LO   = 4'd0,
    FLD_BASE_HI   = 4'd1,
    FLD_SIZE      = 4'd2,
    FLD_CFG       = 4'd3,
    FLD_ACC_FIRST = 4'd4
  } fld_e;

  // configuration word bit positions (software decodes these)
  localparam int CFG_PROT  = 0;
  localparam int CFG_LOCK  = 1;
  localparam int CFG_RDLVL = 3;
  localparam int CFG_WRLVL = 7;
  localparam int CFG_RDDIS = 14;
  localparam int CFG_WRDIS = 18;
  localparam int CFG_SECWR = 23;
  localparam int CFG_SECRD = 24;

  typedef struct packed {
    logic [CG_MAX_REGIONS-1:0] regionWe;
    logic [CG_FIELD_W-1:0]     field;
    logic [CG_WORD_W-1:0]      data;
  } wr_strobe_t;
endpackage

// File: rtl/cg_ctrl.sv
module cg_ctrl
  import cg_pkg::*;
#(
  parameter int NUM_REGIONS = 5,
  parameter int REG_AW      = 7
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   regWe,
  input  logic [REG_AW-1:0]      regAddr,
  input  logic [CG_WORD_W-1:0]   regWdata,
  input  logic                   regSecure,
  input  logic [NUM_REGIONS-1:0] lockVec,
  input  logic [NUM_REGIONS-1:0] protVec,
  output wr_strobe_t             strb
);
  localparam int SEL_W = REG_AW - CG_FIELD_W;

  logic [SEL_W-1:0] regionSel;
  assign regionSel = regAddr[REG_AW-1:CG_FIELD_W];

  always_comb begin
    strb.field    = regAddr[CG_FIELD_W-1:0];
    strb.data     = regWdata;
    strb.regionWe = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (regWe && (int'(regionSel) == i) &&
          (!lockVec[i] || (protVec[i] && regSecure)))
        strb.regionWe[i] = 1'b1;
    end
  end

  // R8: a write reaches at most one region
  p_one_target_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strb.regionWe));

  // R9: a locked region without protect mode never sees a strobe
  p_lock_no_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(lockVec & ~protVec & strb.regionWe[NUM_REGIONS-1:0])) == 1'b0);
endmodule

// File: rtl/cg_datapath.sv
module cg_datapath
  import cg_pkg::*;
#(
  parameter int NUM_REGIONS = 5,
  parameter int ACC_WORDS   = 5,
  parameter int ADDR_W      = 40,
  parameter int CLIENT_W    = 7,
  parameter int REG_AW      = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  wr_strobe_t              strb,
  input  logic [REG_AW-1:0]       regAddr,
  output logic [CG_WORD_W-1:0]    regRdata,
  output logic [NUM_REGIONS-1:0]  lockVec,
  output logic [NUM_REGIONS-1:0]  protVec,
  input  logic                    reqValid,
  input  logic [CLIENT_W-1:0]     reqClient,
  input  logic                    reqWrite,
  input  logic                    reqSecure,
  input  logic [1:0]              reqLevel,
  input  logic [ADDR_W-1:0]       reqAddr,
  output logic                    respValid,
  output logic                    respAllow,
  output logic                    violPulse,
  output logic [$clog2(NUM_REGIONS)-1:0] violRegion
);
  localparam int WL_BITS    = ACC_WORDS * CG_WORD_W;
  localparam int UNIT_SHIFT = 17;
  localparam int UNIT_W     = ADDR_W - UNIT_SHIFT;
  localparam int HI_USED    = ADDR_W - CG_WORD_W;
  localparam int IDX_W      = CLIENT_W + 1;
  localparam int VIDX_W     = $clog2(NUM_REGIONS);
  localparam int SEL_W      = REG_AW - CG_FIELD_W;

  logic [CG_WORD_W-1:0] baseLoQ [NUM_REGIONS];
  logic [CG_WORD_W-1:0] baseHiQ [NUM_REGIONS];
  logic [CG_WORD_W-1:0] sizeQ   [NUM_REGIONS];
  logic [CG_WORD_W-1:0] cfgQ    [NUM_REGIONS];
  logic [WL_BITS-1:0]   wlQ     [NUM_REGIONS];

  logic [NUM_REGIONS-1:0] hit, deny;
  logic [UNIT_W-1:0]      addrUnit;
  logic [IDX_W-1:0]       wlIdx;
  logic                   addrLowUnused;

  assign addrUnit      = reqAddr[ADDR_W-1:UNIT_SHIFT];
  assign addrLowUnused = ^reqAddr[UNIT_SHIFT-1:0];
  assign wlIdx         = {reqClient, reqWrite};

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    logic [UNIT_W-1:0] baseUnit, offUnit;
    logic [3:0]        lvlMask, lvlDis;
    logic              wlBit, lvlOk, bypass;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        baseLoQ[i] <= '0;
        baseHiQ[i] <= '0;
        sizeQ[i]   <= '0;
        cfgQ[i]    <= '0;
        wlQ[i]     <= '0;
      end else if (strb.regionWe[i]) begin
        case (strb.field)
          FLD_BASE_LO: baseLoQ[i] <= strb.data;
          FLD_BASE_HI: baseHiQ[i] <= strb.data;
          FLD_SIZE:    sizeQ[i]   <= strb.data;
          FLD_CFG:     cfgQ[i]    <= strb.data;
          default: begin
            for (int k = 0; k < ACC_WORDS; k++)
              if (strb.field == 4'(int'(FLD_ACC_FIRST) + k))
                wlQ[i][k*CG_WORD_W +: CG_WORD_W] <= strb.data;
          end
        endcase
      end
    end

    assign lockVec[i] = cfgQ[i][CFG_LOCK];
    assign protVec[i] = cfgQ[i][CFG_PROT];
    assign baseUnit   = {baseHiQ[i][HI_USED-1:0], baseLoQ[i][CG_WORD_W-1:UNIT_SHIFT]};
    assign offUnit    = addrUnit - baseUnit;
    assign hit[i]     = (addrUnit >= baseUnit) &&
                        ({{(CG_WORD_W-UNIT_W){1'b0}}, offUnit} < sizeQ[i]);

    always_comb begin
      wlBit = 1'b0;
      if (int'(wlIdx) < WL_BITS) wlBit = wlQ[i][wlIdx];
      lvlMask = reqWrite ? cfgQ[i][CFG_WRLVL +: 4] : cfgQ[i][CFG_RDLVL +: 4];
      lvlDis  = reqWrite ? cfgQ[i][CFG_WRDIS +: 4] : cfgQ[i][CFG_RDDIS +: 4];
      lvlOk   = lvlMask[reqLevel] | lvlDis[reqLevel];
      bypass  = reqSecure & (reqWrite ? cfgQ[i][CFG_SECWR] : cfgQ[i][CFG_SECRD]);
    end

    assign deny[i] = hit[i] && !(bypass || (wlBit && lvlOk));

    // R2: an empty region covers nothing
    p_empty_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (sizeQ[i] == '0) |-> !hit[i]);

    // R9: locked without protect mode freezes the region's words
    p_lock_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cfgQ[i][CFG_LOCK] && !cfgQ[i][CFG_PROT]) |=>
        ($stable(cfgQ[i]) && $stable(sizeQ[i]) && $stable(baseLoQ[i]) &&
         $stable(baseHiQ[i]) && $stable(wlQ[i])));
  end

  logic [VIDX_W-1:0] firstDeny;
  always_comb begin
    firstDeny = '0;
    for (int i = NUM_REGIONS - 1; i >= 0; i--)
      if (deny[i]) firstDeny = VIDX_W'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      respValid  <= 1'b0;
      respAllow  <= 1'b0;
      violPulse  <= 1'b0;
      violRegion <= '0;
    end else begin
      respValid  <= reqValid;
      respAllow  <= reqValid && !(|deny);
      violPulse  <= reqValid && (|deny);
      violRegion <= (reqValid && (|deny)) ? firstDeny : '0;
    end
  end

  logic [SEL_W-1:0] rdSel;
  assign rdSel = regAddr[REG_AW-1:CG_FIELD_W];
  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (int'(rdSel) == i) begin
        case (regAddr[CG_FIELD_W-1:0])
          FLD_BASE_LO: regRdata = baseLoQ[i];
          FLD_BASE_HI: regRdata = baseHiQ[i];
          FLD_SIZE:    regRdata = sizeQ[i];
          FLD_CFG:     regRdata = cfgQ[i];
          default: begin
            for (int k = 0; k < ACC_WORDS; k++)
              if (regAddr[CG_FIELD_W-1:0] == 4'(int'(FLD_ACC_FIRST) + k))
                regRdata = wlQ[i][k*CG_WORD_W +: CG_WORD_W];
          end
        endcase
      end
    end
  end

  // R7: a violation is always a refused, valid verdict
  p_viol_is_deny_r7: assert property (@(posedge clk) disable iff (!rst_n)
    violPulse |-> (respValid && !respAllow));

  // R7: verdicts only follow a request one cycle earlier
  p_resp_after_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
    respValid |-> $past(reqValid));

  // R6: a request outside every region is allowed
  p_outside_allowed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !(|hit)) |=> respAllow);
endmodule

// File: rtl/carveout_guard.sv
module carveout_guard
  import cg_pkg::*;
#(
  parameter int NUM_REGIONS = 5,
  parameter int ACC_WORDS   = 5,
  parameter int ADDR_W      = 40,
  parameter int CLIENT_W    = 7,
  parameter int REG_AW      = $clog2(CG_MAX_REGIONS) + CG_FIELD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 regWe,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [31:0]          regWdata,
  input  logic                 regSecure,
  output logic [31:0]          regRdata,
  input  logic                 reqValid,
  input  logic [CLIENT_W-1:0]  reqClient,
  input  logic                 reqWrite,
  input  logic                 reqSecure,
  input  logic [1:0]           reqLevel,
  input  logic [ADDR_W-1:0]    reqAddr,
  output logic                 respValid,
  output logic                 respAllow,
  output logic                 violPulse,
  output logic [$clog2(NUM_REGIONS)-1:0] violRegion
);
  wr_strobe_t             strb;
  logic [NUM_REGIONS-1:0] lockVec, protVec;

  cg_ctrl #(.NUM_REGIONS(NUM_REGIONS), .REG_AW(REG_AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regSecure(regSecure),
    .lockVec(lockVec), .protVec(protVec), .strb(strb));

  cg_datapath #(.NUM_REGIONS(NUM_REGIONS), .ACC_WORDS(ACC_WORDS),
                .ADDR_W(ADDR_W), .CLIENT_W(CLIENT_W), .REG_AW(REG_AW)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .regAddr(regAddr),
    .regRdata(regRdata), .lockVec(lockVec), .protVec(protVec),
    .reqValid(reqValid), .reqClient(reqClient), .reqWrite(reqWrite),
    .reqSecure(reqSecure), .reqLevel(reqLevel), .reqAddr(reqAddr),
    .respValid(respValid), .respAllow(respAllow),
    .violPulse(violPulse), .violRegion(violRegion));
endmodule

// File: tb/carveout_guard_test.sv
`timescale 1ns/1ps
module carveout_guard_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        regWe = 1'b0;
  logic [6:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic        regSecure = 1'b0;
  logic [31:0] regRdata;
  logic        reqValid = 1'b0;
  logic [6:0]  reqClient = '0;
  logic        reqWrite = 1'b0;
  logic        reqSecure = 1'b0;
  logic [1:0]  reqLevel = '0;
  logic [39:0] reqAddr = '0;
  logic        respValid, respAllow, violPulse;
  logic [2:0]  violRegion;

  int testCnt = 0;
  int failCnt = 0;
  bit finished = 1'b0;

  localparam logic [39:0] BASE = 40'h01_0004_0000;
  localparam logic [39:0] LIM  = 40'h01_0008_0000;

  carveout_guard uut (.*);

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    testCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] rg, input logic [3:0] fld, input logic [31:0] d, input logic sec);
    regAddr = {rg, fld}; regWdata = d; regSecure = sec; regWe = 1'b1;
    @(posedge clk); @(negedge clk);
    regWe = 1'b0; regSecure = 1'b0;
  endtask

  task automatic rdChk(input string tag, input logic [2:0] rg, input logic [3:0] fld, input logic [31:0] exp);
    regAddr = {rg, fld}; #1;
    check(tag, regRdata, exp);
  endtask

  // drive one request, check the verdict one cycle later and the pulse ending after it
  task automatic reqChk(input string tag, input logic [6:0] c, input logic w,
                        input logic [39:0] a, input logic s, input logic [1:0] l,
                        input logic expAllow, input logic [2:0] expReg);
    reqClient = c; reqWrite = w; reqAddr = a; reqSecure = s; reqLevel = l; reqValid = 1'b1;
    @(posedge clk); @(negedge clk);
    reqValid = 1'b0;
    check({tag, " valid"}, respValid, 1);
    check({tag, " allow"}, respAllow, expAllow);
    check({tag, " pulse"}, violPulse, !expAllow);
    if (!expAllow) check({tag, " region"}, violRegion, expReg);
    @(posedge clk); @(negedge clk);
    check({tag, " pulse end"}, {respValid, violPulse}, 0);
  endtask

  task automatic setRange(input logic [2:0] rg, input logic [31:0] sz);
    wr(rg, 4'd0, BASE[31:0], 0);
    wr(rg, 4'd1, {24'd0, BASE[39:32]}, 0);
    wr(rg, 4'd2, sz, 0);
  endtask

  task automatic t_reset;
    check("R1 respValid", respValid, 0);
    check("R1 violPulse", violPulse, 0);
    rdChk("R1 base lo", 3'd0, 4'd0, 0);
    rdChk("R1 cfg", 3'd4, 4'd3, 0);
    rdChk("R1 acc4", 3'd2, 4'd8, 0);
    reqChk("R1 empty allow", 7'd3, 0, BASE, 0, 0, 1, 0);
  endtask

  task automatic t_readback;
    wr(3'd1, 4'd0, 32'hA5A5_0000, 0); rdChk("R8 base lo", 3'd1, 4'd0, 32'hA5A5_0000);
    wr(3'd1, 4'd1, 32'hDEAD_BEEF, 0); rdChk("R8 base hi", 3'd1, 4'd1, 32'hDEAD_BEEF);
    wr(3'd1, 4'd6, 32'h1357_9BDF, 0); rdChk("R8 acc2", 3'd1, 4'd6, 32'h1357_9BDF);
    wr(3'd1, 4'd9, 32'hFFFF_FFFF, 0); rdChk("R8 unmapped field", 3'd1, 4'd9, 0);
    wr(3'd6, 4'd0, 32'h1111_0000, 0); rdChk("R8 absent region", 3'd6, 4'd0, 0);
    wr(3'd1, 4'd0, 0, 0); wr(3'd1, 4'd1, 0, 0); wr(3'd1, 4'd6, 0, 0);
  endtask

  task automatic t_range;
    setRange(3'd0, 32'd2);
    reqChk("R2 below base", 7'd3, 0, BASE - 1, 0, 0, 1, 0);
    reqChk("R2 at base", 7'd3, 0, BASE, 0, 0, 0, 0);
    reqChk("R2 last byte", 7'd3, 0, LIM - 1, 0, 0, 0, 0);
    reqChk("R6 at limit outside", 7'd3, 0, LIM, 0, 0, 1, 0);
  endtask

  task automatic t_whitelist;
    wr(3'd0, 4'd3, 32'h0000_07F8, 0);
    wr(3'd0, 4'd4, 32'h0000_0040, 0);
    reqChk("R3 client3 read ok", 7'd3, 0, BASE, 0, 0, 1, 0);
    reqChk("R3 client3 write denied", 7'd3, 1, BASE, 0, 0, 0, 0);
    reqChk("R3 client70 read denied", 7'd70, 0, BASE, 0, 0, 0, 0);
    wr(3'd0, 4'd8, 32'h0000_1000, 0);
    reqChk("R3 client70 read ok", 7'd70, 0, BASE + 40'h100, 0, 0, 1, 0);
    reqChk("R3 index past 160", 7'd100, 0, BASE, 0, 0, 0, 0);
  endtask

  task automatic t_levels;
    wr(3'd0, 4'd3, 32'h0000_0790, 0);
    reqChk("R4 read level1 ok", 7'd3, 0, BASE, 0, 2'd1, 1, 0);
    reqChk("R4 read level2 denied", 7'd3, 0, BASE, 0, 2'd2, 0, 0);
    wr(3'd0, 4'd3, 32'h0001_0790, 0);
    reqChk("R4 level2 check off", 7'd3, 0, BASE, 0, 2'd2, 1, 0);
    reqChk("R4 read level3 denied", 7'd3, 0, BASE, 0, 2'd3, 0, 0);
  endtask

  task automatic t_bypass;
    wr(3'd0, 4'd3, 32'h0100_0000, 0);
    reqChk("R5 secure read bypass", 7'd3, 0, BASE, 1, 0, 1, 0);
    reqChk("R5 nonsecure read denied", 7'd3, 0, BASE, 0, 0, 0, 0);
    reqChk("R5 secure write no bypass", 7'd3, 1, BASE, 1, 0, 0, 0);
    wr(3'd0, 4'd3, 32'h0080_0000, 0);
    reqChk("R5 secure write bypass", 7'd5, 1, BASE, 1, 0, 1, 0);
  endtask

  task automatic t_overlap;
    for (int k = 4; k <= 8; k++) wr(3'd0, 4'(k), 32'hFFFF_FFFF, 0);
    wr(3'd0, 4'd3, 32'h0000_07F8, 0);
    reqChk("R6 permissive region", 7'd9, 1, BASE, 0, 2'd3, 1, 0);
    setRange(3'd1, 32'd2);
    reqChk("R6 overlap denied by 1", 7'd9, 1, BASE, 0, 0, 0, 1);
    setRange(3'd2, 32'd2);
    reqChk("R7 lowest denier reported", 7'd9, 0, BASE, 0, 0, 0, 1);
    wr(3'd1, 4'd2, 0, 0);
    reqChk("R2 size zero disables", 7'd9, 0, BASE, 0, 0, 0, 2);
    wr(3'd2, 4'd2, 0, 0);
    reqChk("R6 all allow", 7'd9, 0, BASE, 0, 0, 1, 0);
  endtask

  task automatic t_lock;
    wr(3'd3, 4'd3, 32'h2, 0);
    wr(3'd3, 4'd2, 32'd7, 0); rdChk("R9 locked nonsecure", 3'd3, 4'd2, 0);
    wr(3'd3, 4'd2, 32'd7, 1); rdChk("R9 locked secure no prot", 3'd3, 4'd2, 0);
    wr(3'd3, 4'd3, 32'h0, 1); rdChk("R9 lock self frozen", 3'd3, 4'd3, 32'h2);
    wr(3'd4, 4'd3, 32'h3, 0);
    wr(3'd4, 4'd2, 32'd5, 0); rdChk("R9 prot nonsecure ignored", 3'd4, 4'd2, 0);
    wr(3'd4, 4'd2, 32'd5, 1); rdChk("R9 prot secure accepted", 3'd4, 4'd2, 32'd5);
    wr(3'd2, 4'd0, 32'h1234_0000, 0); rdChk("R10 other region free", 3'd2, 4'd0, 32'h1234_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_readback;
    t_range;
    t_whitelist;
    t_levels;
    t_bypass;
    t_overlap;
    t_lock;
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testCnt++; failCnt++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end
endmodule